// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This unit keeps an asynchronous DRAM bank refreshed on behalf of a memory controller. A 16-bit down-counting timer, reloaded from a programmable period, marks each refresh interval. Each expiry adds one refresh to a small pending stack. While the stack is non-empty the unit raises a request towards the bus arbiter. Once the grant arrives it runs every pending refresh back to back as CAS-before-RAS cycles, and it keeps the request raised until the stack is empty.

Configuration is loaded with a single write strobe: the period, an enable bit, the lead of CAS ahead of RAS and the RAS low time. The external reset input only clears the sticky overflow flag. The timer, the stack and any refresh cycle keep running while it is held, so the memory stays refreshed through a board reset.

Top module: `dram_refresh_sched`

## Requirements
- R1: Every refresh drives CAS low before RAS. RAS is low only while CAS is low, and both return high on the same cycle.
- R2: With refresh enabled, the timer expires once every `period+1` cycles. A configuration write reloads it with the written period and restarts the interval, and no expiry is counted on the write cycle.
- R3: While the enable bit is 0 no expiry is counted and the pending count is held at zero. A refresh already in progress when refresh is disabled runs to completion, and no further refresh follows it.
- R4: Each expiry adds one to the pending count. `refresh_req` is high exactly while the pending count is non-zero or a refresh cycle is in progress.
- R5: The pending count saturates at 7. An expiry that finds it at 7 with no refresh finishing on that cycle is dropped and sets `refresh_ovf`, which then stays high until it is cleared.
- R6: A refresh burst starts from idle only on a cycle when `refresh_gnt` is high. Each refresh lowers the pending count by one as its RAS pulse ends. All pending refreshes then run consecutively without `refresh_req` dropping, whatever `refresh_gnt` does.
- R7: CAS leads RAS by `cfg_cas_lead+1` cycles (2-bit code, 1 to 4 cycles).
- R8: RAS stays low for `cfg_ras_width+2` cycles for codes 0 to 6, and for 8 cycles for code 7.
- R9: Between stacked refreshes, RAS and CAS are both high for exactly 2 cycles.
- R10: A high `ext_rst` clears `refresh_ovf` and affects nothing else: the timer, the pending count and the refresh cycles keep running.
- R11: After reset, RAS and CAS are high, `refresh_req` and `refresh_ovf` are low, and refresh is disabled with every configuration field at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_rst | input | 1 | External reset; clears the overflow flag only |
| cfg_wr | input | 1 | Loads all configuration fields and reloads the timer |
| cfg_period | input | 16 | Refresh interval minus one, in cycles |
| cfg_enable | input | 1 | 1 enables refresh |
| cfg_cas_lead | input | 2 | CAS-to-RAS lead code |
| cfg_ras_width | input | 3 | RAS low-time code |
| refresh_gnt | input | 1 | Bus grant from the arbiter |
| refresh_req | output | 1 | Bus request towards the arbiter |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| refresh_ovf | output | 1 | Sticky flag: an expiry was dropped |

## Verification
The hardest states to reach are a full pending stack that then drains, and the overflow caused by one more expiry. The bench holds the grant low with a short period until the stack saturates and expiries are dropped, then opens the grant and counts the RAS pulses. A second hard case is disabling refresh in the middle of a cycle. The bench issues the disabling write while CAS is already low and checks that exactly one refresh completes. A long phase with a random grant and rotating pulse timings lets expiries, stack drains and grant changes fall on the same cycles.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_CAS  = 2'd1,
    RS_RAS  = 2'd2,
    RS_GAP  = 2'd3
  } rstate_e;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic [TW-1:0] period_i,
  output logic          expire_o
);
  logic [TW-1:0] tmr_q, tmr_d;
  logic          zero;

  assign zero     = (tmr_q == '0);
  assign expire_o = en_i && zero && !load_i;

  always_comb begin
    if (load_i)      tmr_d = load_val_i;
    else if (!en_i)  tmr_d = period_i;
    else if (zero)   tmr_d = period_i;
    else             tmr_d = tmr_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  // R2
  expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !load_i) |=> (tmr_q == $past(period_i)));
endmodule

// File: rtl/refresh_pending_stack.sv
module refresh_pending_stack #(
  parameter int PEND_MAX = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic inc_i,
  input  logic dec_i,
  input  logic clr_ovf_i,
  output logic nz_o,
  output logic ovf_o
);
  localparam int PEND_W = $clog2(PEND_MAX + 1);

  logic [PEND_W-1:0] cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              dec, full, ovf_set;

  assign dec   = dec_i && (cnt_q != '0);
  assign full  = (cnt_q == PEND_W'(PEND_MAX));
  assign nz_o  = (cnt_q != '0);
  assign ovf_o = ovf_q;

  always_comb begin
    cnt_d   = cnt_q;
    ovf_set = 1'b0;
    if (!en_i) begin
      cnt_d = '0;
    end else if (inc_i && !dec) begin
      if (full) ovf_set = 1'b1;
      else      cnt_d   = cnt_q + PEND_W'(1);
    end else if (dec && !inc_i) begin
      cnt_d = cnt_q - PEND_W'(1);
    end
    if (clr_ovf_i)    ovf_d = 1'b0;
    else if (ovf_set) ovf_d = 1'b1;
    else              ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf_i) |=> ovf_q);
  // R3
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && inc_i && !dec && !clr_ovf_i && en_i) |=> (ovf_q && cnt_q == PEND_W'(PEND_MAX)));
endmodule

// File: rtl/refresh_cbr_sequencer.sv
module refresh_cbr_sequencer
  import dram_refresh_pkg::*;
#(
  parameter int LEAD_W  = 2,
  parameter int RASW_W  = 3,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              pend_nz_i,
  input  logic              gnt_i,
  input  logic [LEAD_W-1:0] lead_code_i,
  input  logic [RASW_W-1:0] ras_code_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cas_n_o,
  output logic              ras_n_o
);
  localparam int LR_W  = (LEAD_W > RASW_W) ? LEAD_W : RASW_W;
  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam int CNT_W = (LR_W > GAP_W) ? LR_W : GAP_W;

  rstate_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lead_init, ras_init;
  logic             cnt_zero;

  assign lead_init = CNT_W'(lead_code_i);
  assign ras_init  = (&ras_code_i) ? CNT_W'(ras_code_i) : CNT_W'(ras_code_i) + CNT_W'(1);
  assign cnt_zero  = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_o  = 1'b0;
    unique case (state_q)
      RS_IDLE: if (pend_nz_i && en_i && gnt_i) begin
        state_d = RS_CAS;
        cnt_d   = lead_init;
      end
      RS_CAS: if (cnt_zero) begin
        state_d = RS_RAS;
        cnt_d   = ras_init;
      end else cnt_d = cnt_q - CNT_W'(1);
      RS_RAS: if (cnt_zero) begin
        state_d = RS_GAP;
        cnt_d   = CNT_W'(GAP_CYC - 1);
        done_o  = 1'b1;
      end else cnt_d = cnt_q - CNT_W'(1);
      RS_GAP: if (cnt_zero) begin
        if (pend_nz_i && en_i) begin
          state_d = RS_CAS;
          cnt_d   = lead_init;
        end else state_d = RS_IDLE;
      end else cnt_d = cnt_q - CNT_W'(1);
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o  = (state_q != RS_IDLE);
  assign cas_n_o = !((state_q == RS_CAS) || (state_q == RS_RAS));
  assign ras_n_o = !(state_q == RS_RAS);

  // R1
  cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> $past(!cas_n_o));
  // R6
  start_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n_o) && $past(state_q == RS_IDLE)) |-> $past(gnt_i));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int TW       = 16,
  parameter int PEND_MAX = 7,
  parameter int LEAD_W   = 2,
  parameter int RASW_W   = 3,
  parameter int GAP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst,
  input  logic              cfg_wr,
  input  logic [TW-1:0]     cfg_period,
  input  logic              cfg_enable,
  input  logic [LEAD_W-1:0] cfg_cas_lead,
  input  logic [RASW_W-1:0] cfg_ras_width,
  input  logic              refresh_gnt,
  output logic              refresh_req,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              refresh_ovf
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [TW-1:0]     period_q;
  logic              en_q;
  logic [LEAD_W-1:0] lead_q;
  logic [RASW_W-1:0] rasw_q;
  logic              expire, pend_nz, busy, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      period_q <= '0;
      en_q     <= 1'b0;
      lead_q   <= '0;
      rasw_q   <= '0;
    end else if (cfg_wr) begin
      period_q <= cfg_period;
      en_q     <= cfg_enable;
      lead_q   <= cfg_cas_lead;
      rasw_q   <= cfg_ras_width;
    end
  end

  refresh_interval_timer #(.TW(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en_i       (en_q),
    .load_i     (cfg_wr),
    .load_val_i (cfg_period),
    .period_i   (period_q),
    .expire_o   (expire)
  );

  refresh_pending_stack #(.PEND_MAX(PEND_MAX)) u_stack (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en_i      (en_q),
    .inc_i     (expire),
    .dec_i     (done),
    .clr_ovf_i (ext_rst),
    .nz_o      (pend_nz),
    .ovf_o     (refresh_ovf)
  );

  refresh_cbr_sequencer #(
    .LEAD_W (LEAD_W),
    .RASW_W (RASW_W),
    .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (en_q),
    .pend_nz_i   (pend_nz),
    .gnt_i       (refresh_gnt),
    .lead_code_i (lead_q),
    .ras_code_i  (rasw_q),
    .busy_o      (busy),
    .done_o      (done),
    .cas_n_o     (dram_cas_n),
    .ras_n_o     (dram_ras_n)
  );

  assign refresh_req = busy || pend_nz;

  // R1
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dram_ras_n |-> !dram_cas_n);
  // R6
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dram_cas_n |-> refresh_req);
endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_rst = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_period = '0;
  logic        cfg_enable = 1'b0;
  logic [1:0]  cfg_cas_lead = '0;
  logic [2:0]  cfg_ras_width = '0;
  logic        refresh_gnt = 1'b0;
  logic        refresh_req, dram_ras_n, dram_cas_n, refresh_ovf;

  always #2.5 clk = ~clk;

  dram_refresh_sched uut (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .cfg_wr(cfg_wr),
    .cfg_period(cfg_period), .cfg_enable(cfg_enable),
    .cfg_cas_lead(cfg_cas_lead), .cfg_ras_width(cfg_ras_width),
    .refresh_gnt(refresh_gnt), .refresh_req(refresh_req),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .refresh_ovf(refresh_ovf)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int ras_falls = 0;
  logic prev_ras = 1'b1;

  // behavioural reference model
  bit s1 = 0, s2 = 0;
  int m_per = 0, m_tim = 0, m_pend = 0, m_pos = -1;
  int m_lead = 1, m_wcyc = 2, cur_l = 1, cur_w = 2;
  bit m_en = 0, m_ovf = 0;

  function automatic int wcyc_of(input int code);
    return (code == 7) ? 8 : code + 2;   // R8
  endfunction

  always @(posedge clk) begin
    bit tick, done, start, ovf_ev;
    int n_pos, n_pend, n_tim;
    if (!s2) begin
      m_per = 0; m_tim = 0; m_pend = 0; m_pos = -1; m_en = 0; m_ovf = 0;
      m_lead = 1; m_wcyc = 2; cur_l = 1; cur_w = 2;
    end else begin
      tick   = m_en && (m_tim == 0) && !cfg_wr;
      done   = (m_pos == cur_l + cur_w - 1);
      start  = 0;
      ovf_ev = 0;
      n_pos  = m_pos;
      if (m_pos < 0) begin
        if (m_pend != 0 && m_en && refresh_gnt) start = 1;
      end else if (m_pos == cur_l + cur_w + 1) begin
        if (m_pend != 0 && m_en) start = 1; else n_pos = -1;
      end else n_pos = m_pos + 1;
      if (start) begin n_pos = 0; cur_l = m_lead; end
      if (n_pos >= 0 && n_pos == cur_l && m_pos == cur_l - 1) cur_w = m_wcyc;
      n_pend = m_pend;
      if (!m_en) n_pend = 0;
      else begin
        int d;
        d = (done && m_pend > 0) ? 1 : 0;
        if (tick && d == 0 && m_pend == 7) ovf_ev = 1;
        else n_pend = m_pend + (tick ? 1 : 0) - d;
      end
      if (ext_rst) m_ovf = 0; else if (ovf_ev) m_ovf = 1;
      if (cfg_wr) n_tim = cfg_period;
      else if (!m_en || m_tim == 0) n_tim = m_per;
      else n_tim = m_tim - 1;
      if (cfg_wr) begin
        m_per = cfg_period; m_en = cfg_enable;
        m_lead = cfg_cas_lead + 1; m_wcyc = wcyc_of(cfg_ras_width);
      end
      m_pos = n_pos; m_pend = n_pend; m_tim = n_tim;
    end
    if (!rst_n) begin s1 = 0; s2 = 0; end
    else begin s2 = s1; s1 = 1; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_cas, e_ras, e_req;
      e_cas = !(m_pos >= 0 && m_pos < cur_l + cur_w);
      e_ras = !(m_pos >= cur_l && m_pos < cur_l + cur_w);
      e_req = (m_pos >= 0) || (m_pend != 0);
      check(dram_cas_n == e_cas, "R1/R7/R9 cas_n", dram_cas_n, e_cas);
      check(dram_ras_n == e_ras, "R1/R8/R9 ras_n", dram_ras_n, e_ras);
      check(refresh_req == e_req, "R4/R6 req", refresh_req, e_req);
      check(refresh_ovf == m_ovf, "R5/R10 ovf", refresh_ovf, m_ovf);
    end
    if (prev_ras && !dram_ras_n) ras_falls++;
    prev_ras = dram_ras_n;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int p, input bit e, input int l, input int w);
    @(negedge clk);
    cfg_wr = 1; cfg_period = 16'(p); cfg_enable = e;
    cfg_cas_lead = 2'(l); cfg_ras_width = 3'(w);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic summary;
    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(4);
    // R11 reset state
    check(dram_ras_n && dram_cas_n, "R11 strobes high", {dram_ras_n, dram_cas_n}, 3);
    check(!refresh_req, "R11 req low", refresh_req, 0);
    check(!refresh_ovf, "R11 ovf low", refresh_ovf, 0);
    refresh_gnt = 1;
    cyc(40);
    check(ras_falls == 0, "R11 disabled after reset", ras_falls, 0);

    // R2/R7/R8 single refreshes with grant always on
    cfg(20, 1, 1, 2);
    cyc(150);
    check(ras_falls >= 6, "R2 periodic refresh", ras_falls, 6);

    // R5 starve until saturation, then drain
    refresh_gnt = 0;
    cfg(5, 1, 1, 2);
    cyc(100);
    check(refresh_ovf, "R5 overflow set", refresh_ovf, 1);
    check(refresh_req, "R4 req while pending", refresh_req, 1);
    cfg(2000, 1, 1, 2);
    ras_falls = 0;
    refresh_gnt = 1;
    cyc(1);
    refresh_gnt = 0;            // R6 burst continues without grant
    cyc(90);
    check(ras_falls == 7, "R5/R6 drained burst", ras_falls, 7);
    check(!refresh_req, "R6 req released", refresh_req, 0);

    // R10 ext_rst clears overflow only; refresh runs on
    ext_rst = 1;
    cyc(1);
    check(!refresh_ovf, "R10 ovf cleared", refresh_ovf, 0);
    refresh_gnt = 1;
    cfg(12, 1, 0, 0);
    ras_falls = 0;
    cyc(100);
    check(ras_falls >= 6, "R10 refresh during ext_rst", ras_falls, 6);
    ext_rst = 0;

    // R7/R8 extreme timings
    cfg(30, 1, 3, 7);
    cyc(120);
    cfg(30, 1, 2, 6);
    cyc(120);

    // R3 disable mid-cycle
    refresh_gnt = 0;
    cfg(4, 1, 3, 5);
    cyc(40);
    ras_falls = 0;
    refresh_gnt = 1;
    cyc(2);
    check(!dram_cas_n, "R3 cycle in progress", dram_cas_n, 0);
    cfg(4, 0, 3, 5);
    cyc(40);
    check(ras_falls == 1, "R3 in-progress cycle finishes", ras_falls, 1);
    check(!refresh_req, "R3 no request when disabled", refresh_req, 0);

    // R2 period rewrite reloads timer
    cfg(50, 1, 0, 1);
    cyc(20);
    cfg(8, 1, 0, 1);
    cyc(60);

    // random grant, rotating timings
    for (int k = 0; k < 8; k++) begin
      cfg(6 + k * 3, 1, k % 4, k);
      for (int i = 0; i < 250; i++) begin
        @(negedge clk);
        refresh_gnt = ($urandom % 4) == 0;
        ext_rst = ($urandom % 64) == 0;
      end
    end
    ext_rst = 0;
    refresh_gnt = 1;
    cyc(50);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule